// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits between the capture of host write cycles and the page-load controller of a byte-wide non-volatile memory. Every captured write (address and data) enters through a valid/ready stream. The block compares it against multi-byte command sequences that switch a persistent write-protect mode on or off. Each write leaves on a second valid/ready stream with its address and data unchanged and a two-bit verdict. The verdict tells the controller to drop a command byte, store a data byte, or treat the write as blocked. A blocked write still opens a busy period, but nothing is stored.

The protect flag changes only when the controller pulses `period_end`, which marks the end of the internal write period. It changes only if a complete enable or disable sequence was entered during that period. The flag sits in a register that is cleared only by the dedicated `nv_rst_n` input. The ordinary reset leaves it alone. The input stream accepts a new write when the output register is empty or is being drained in the same cycle (`wr_ready = !cls_valid || cls_ready`). While `cls_ready` is low, a pending verdict stays frozen and further writes wait upstream.

Top module: `swp_guard`

## Requirements
- R1: After `rst_n` is released, `cls_valid` is 0 and `wr_ready` is 1. After `nv_rst_n` is asserted, `protect_o` is 0.
- R2: Only the low 15 address bits are compared. The enable sequence is AA at 5555, then 55 at 2AAA, then A0 at 5555. Each of its bytes is reported as kind 1 (command). `protect_o` becomes 1 at the next `period_end` pulse, whether or not data bytes followed.
- R3: The disable sequence is six bytes: AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555. Each byte is reported as kind 1. `protect_o` becomes 0 at the next `period_end` pulse.
- R4: A write that is not part of a sequence and not inside an unlocked window is reported as kind 3 (blocked) when protected, and as kind 2 (data) when not.
- R5: After a complete enable sequence, every write is kind 2, even when protected, until the next `period_end`.
- R6: If at least `GAP_LIMIT` clock edges pass without an accepted write, a partly entered sequence is abandoned. The next write is judged as if no byte had been entered. With one edge fewer, the sequence continues.
- R7: A byte that breaks a partly entered sequence returns the matcher to its start. That same byte is then tested as a first command byte (AA@5555), and if it matches it counts as step one.
- R8: `protect_o` changes only at a `period_end` pulse or through `nv_rst_n`. `rst_n` never changes it.
- R9: An accepted write appears on the output one cycle later with the same address and data. While `cls_valid` is 1 and `cls_ready` is 0, all output fields hold steady.
- R10: A write accepted in the same cycle as a `period_end` pulse is judged against the state after the period closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the matcher, window and output stage |
| nv_rst_n | input | 1 | Active-low reset of the persistent protect flag only |
| period_end | input | 1 | One-cycle pulse at the end of an internal write period |
| wr_valid | input | 1 | Captured write present |
| wr_ready | output | 1 | Block can take the write this cycle |
| wr_addr | input | ADDR_W | Captured write address |
| wr_data | input | DATA_W | Captured write data |
| cls_valid | output | 1 | Verdict present |
| cls_ready | input | 1 | Controller takes the verdict |
| cls_kind | output | 2 | 1 command, 2 data, 3 blocked |
| cls_addr | output | ADDR_W | Address of the judged write |
| cls_data | output | DATA_W | Data of the judged write |
| protect_o | output | 1 | Current write-protect state |

## Verification
The hardest situations to reach are the ones that depend on gap length and on edge coincidence. One is a sequence abandoned after exactly `GAP_LIMIT` idle edges, set against the same sequence surviving with one edge fewer. The other is a write accepted in the very cycle that a period closes. The stimulus keeps output back-pressure off in these phases, so the number of idle edges between two accepted writes is set exactly by the driver. It also raises `period_end` together with `wr_valid` while the output is empty. Separately, a phase with periodic `cls_ready` stalls runs the disable sequence, to show that verdicts survive back-pressure.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_CMD   = 2'd1,
    KIND_DATA  = 2'd2,
    KIND_BLOCK = 2'd3
  } wr_kind_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_SET  = 2'd1,
    PEND_CLR  = 2'd2
  } pend_e;

  localparam int KEY_W     = 15;
  localparam int SEQ_STEPS = 6;
  localparam int STEP_W    = $clog2(SEQ_STEPS);
  localparam int STEP_OP   = 2;
  localparam int STEP_LAST = SEQ_STEPS - 1;

  localparam logic [KEY_W-1:0] KEY_ADDR_HI = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_ADDR_LO = 15'h2AAA;
  localparam logic [7:0] KEY_BYTE_0 = 8'hAA;
  localparam logic [7:0] KEY_BYTE_1 = 8'h55;
  localparam logic [7:0] OP_SET     = 8'hA0;
  localparam logic [7:0] OP_MORE    = 8'h80;
  localparam logic [7:0] OP_CLR     = 8'h20;

  typedef struct packed {
    logic [KEY_W-1:0] addr;
    logic [7:0]       data;
  } key_t;

  function automatic key_t key_at(input int step);
    key_t k;
    case (step)
      0:       k = '{addr: KEY_ADDR_HI, data: KEY_BYTE_0};
      1:       k = '{addr: KEY_ADDR_LO, data: KEY_BYTE_1};
      2:       k = '{addr: KEY_ADDR_HI, data: OP_SET};
      3:       k = '{addr: KEY_ADDR_HI, data: KEY_BYTE_0};
      4:       k = '{addr: KEY_ADDR_LO, data: KEY_BYTE_1};
      default: k = '{addr: KEY_ADDR_HI, data: OP_CLR};
    endcase
    return k;
  endfunction

endpackage

// File: rtl/swp_gap_timer.sv
module swp_gap_timer #(
  parameter int GAP_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic expired
);
  localparam int GAP_W = $clog2(GAP_LIMIT + 1);
  localparam logic [GAP_W-1:0] LIMIT_V = GAP_W'(GAP_LIMIT);

  logic [GAP_W-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (accept) begin
      idle_q <= '0;
    end else if (idle_q < LIMIT_V) begin
      idle_q <= idle_q + GAP_W'(1);
    end
  end

  assign expired = (idle_q >= LIMIT_V);
endmodule

// File: rtl/swp_seq_matcher.sv
module swp_seq_matcher
  import swp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clear,
  input  logic [KEY_W-1:0]  key_addr,
  input  logic [7:0]        key_data,
  output logic              is_cmd,
  output logic              done_set,
  output logic              done_clr,
  output logic [STEP_W-1:0] step_q
);
  logic [SEQ_STEPS-1:0] step_hit;
  logic [STEP_W-1:0]    step_base;
  logic [STEP_W-1:0]    step_d;
  logic                 cur_hit;

  for (genvar s = 0; s < SEQ_STEPS; s++) begin : g_key
    localparam key_t K = key_at(s);
    if (s == STEP_OP) begin : g_fork
      assign step_hit[s] = (key_addr == K.addr) &&
                           ((key_data == OP_SET) || (key_data == OP_MORE));
    end else begin : g_plain
      assign step_hit[s] = (key_addr == K.addr) && (key_data == K.data);
    end
  end

  assign step_base = clear ? '0 : step_q;
  assign cur_hit   = (int'(step_base) < SEQ_STEPS) && step_hit[step_base];

  always_comb begin
    is_cmd   = 1'b0;
    done_set = 1'b0;
    done_clr = 1'b0;
    step_d   = step_base;
    if (en) begin
      if (cur_hit) begin
        is_cmd = 1'b1;
        if (int'(step_base) == STEP_OP && key_data == OP_SET) begin
          done_set = 1'b1;
          step_d   = '0;
        end else if (int'(step_base) == STEP_LAST) begin
          done_clr = 1'b1;
          step_d   = '0;
        end else begin
          step_d = step_base + STEP_W'(1);
        end
      end else if (step_hit[0]) begin
        is_cmd = 1'b1;
        step_d = STEP_W'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end
endmodule

// File: rtl/swp_protect_state.sv
module swp_protect_state
  import swp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nv_rst_n,
  input  logic period_end,
  input  logic done_set,
  input  logic done_clr,
  output logic protect_q,
  output logic armed_q,
  output logic prot_eff,
  output logic armed_eff
);
  pend_e pend_q;
  pend_e pend_eff;

  always_comb begin
    prot_eff  = protect_q;
    armed_eff = armed_q;
    pend_eff  = pend_q;
    if (period_end) begin
      if (pend_q == PEND_SET)      prot_eff = 1'b1;
      else if (pend_q == PEND_CLR) prot_eff = 1'b0;
      armed_eff = 1'b0;
      pend_eff  = PEND_NONE;
    end
  end

  always_ff @(posedge clk or negedge nv_rst_n) begin
    if (!nv_rst_n) protect_q <= 1'b0;
    else           protect_q <= prot_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= PEND_NONE;
    end else begin
      armed_q <= armed_eff | done_set;
      if (done_set)      pend_q <= PEND_SET;
      else if (done_clr) pend_q <= PEND_CLR;
      else               pend_q <= pend_eff;
    end
  end
endmodule

// File: rtl/swp_out_stage.sv
module swp_out_stage
  import swp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  wr_kind_e          in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output wr_kind_e          out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= KIND_NONE;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_kind  <= in_kind;
      out_addr  <= in_addr;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/swp_guard.sv
module swp_guard
  import swp_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int GAP_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_rst_n,
  input  logic              period_end,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cls_valid,
  input  logic              cls_ready,
  output logic [1:0]        cls_kind,
  output logic [ADDR_W-1:0] cls_addr,
  output logic [DATA_W-1:0] cls_data,
  output logic              protect_o
);
  logic     accept;
  logic     gap_expired;
  logic     is_cmd, done_set, done_clr;
  logic     protect_q, armed_q, prot_eff, armed_eff;
  logic [STEP_W-1:0] step_q;
  wr_kind_e kind_d;
  wr_kind_e kind_q;

  assign accept = wr_valid && wr_ready;

  swp_gap_timer #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .expired (gap_expired)
  );

  swp_protect_state u_prot (
    .clk        (clk),
    .rst_n      (rst_n),
    .nv_rst_n   (nv_rst_n),
    .period_end (period_end),
    .done_set   (done_set),
    .done_clr   (done_clr),
    .protect_q  (protect_q),
    .armed_q    (armed_q),
    .prot_eff   (prot_eff),
    .armed_eff  (armed_eff)
  );

  swp_seq_matcher u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (accept && !armed_eff),
    .clear    (period_end || gap_expired),
    .key_addr (wr_addr[KEY_W-1:0]),
    .key_data (wr_data[7:0]),
    .is_cmd   (is_cmd),
    .done_set (done_set),
    .done_clr (done_clr),
    .step_q   (step_q)
  );

  always_comb begin
    if (armed_eff)     kind_d = KIND_DATA;
    else if (is_cmd)   kind_d = KIND_CMD;
    else if (prot_eff) kind_d = KIND_BLOCK;
    else               kind_d = KIND_DATA;
  end

  swp_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .in_kind   (kind_d),
    .in_addr   (wr_addr),
    .in_data   (wr_data),
    .out_valid (cls_valid),
    .out_ready (cls_ready),
    .out_kind  (kind_q),
    .out_addr  (cls_addr),
    .out_data  (cls_data)
  );

  assign cls_kind  = kind_q;
  assign protect_o = protect_q;
endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nv_rst_n,
  input logic              period_end,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              cls_valid,
  input logic              cls_ready,
  input logic [1:0]        cls_kind,
  input logic [ADDR_W-1:0] cls_addr,
  input logic [DATA_W-1:0] cls_data,
  input logic              protect_o,
  input logic              armed_q,
  input logic [STEP_W-1:0] step_q
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && !cls_ready) |=> (cls_valid && $stable(cls_kind) &&
                                   $stable(cls_addr) && $stable(cls_data)));

  assert_accept_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> cls_valid);

  assert_prot_at_end_R8: assert property (@(posedge clk) disable iff (!nv_rst_n)
    !period_end |=> $stable(protect_o));

  assert_kind_known_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |-> (cls_kind != 2'd0));

  assert_window_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && armed_q && !period_end) |=> (cls_kind == 2'd2));

  assert_step_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step_q) < 6);
endmodule

bind swp_guard swp_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(swp_pkg::STEP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nv_rst_n   (nv_rst_n),
  .period_end (period_end),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .cls_valid  (cls_valid),
  .cls_ready  (cls_ready),
  .cls_kind   (cls_kind),
  .cls_addr   (cls_addr),
  .cls_data   (cls_data),
  .protect_o  (protect_o),
  .armed_q    (u_prot.armed_q),
  .step_q     (u_match.step_q)
);

// File: tb/swp_guard_bench.sv
module swp_guard_bench;
  localparam int ADDR_W    = 17;
  localparam int DATA_W    = 8;
  localparam int GAP_LIMIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0, nv_rst_n = 1'b0, period_end = 1'b0;
  logic wr_valid = 1'b0, cls_ready = 1'b1;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_ready, cls_valid, protect_o;
  logic [1:0] cls_kind;
  logic [ADDR_W-1:0] cls_addr;
  logic [DATA_W-1:0] cls_data;

  always #5 clk = ~clk;

  swp_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_LIMIT(GAP_LIMIT)) u_swp_guard (
    .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .period_end(period_end),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .cls_valid(cls_valid), .cls_ready(cls_ready), .cls_kind(cls_kind),
    .cls_addr(cls_addr), .cls_data(cls_data), .protect_o(protect_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference state
  int  m_step = 0, m_idle = 0, m_pend = 0;
  bit  m_prot = 0, m_arm = 0;
  int  q_kind[$], q_addr[$], q_data[$];
  string q_tag[$];
  bit  acc_seen = 0, prev_stall = 0;
  int  prev_kind = 0, prev_addr = 0, prev_data = 0;
  bit  stall_mode = 0;
  int  cyc = 0;

  const int key_a[6] = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
  const int key_d[6] = '{'hAA, 'h55, 'hA0, 'hAA, 'h55, 'h20};

  function automatic bit key_ok(input int s, input int a, input int d);
    return (a == key_a[s]) && ((d == key_d[s]) || (s == 2 && d == 'h80));
  endfunction

  always @(negedge clk) begin
    bit acc, hs, arm, pr, gap_hit;
    int st, pend, nk, a, d;
    string tag;
    acc = wr_valid && wr_ready;
    hs  = cls_valid && cls_ready;
    acc_seen = acc;
    if (!nv_rst_n) m_prot = 0;
    if (!rst_n) begin
      m_step = 0; m_idle = 0; m_arm = 0; m_pend = 0;
      q_kind.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
      prev_stall = 0;
    end else begin
      check(protect_o == m_prot, "R8", "protect flag", int'(protect_o), int'(m_prot));
      if (prev_stall)
        check(cls_valid && int'(cls_kind) == prev_kind && int'(cls_addr) == prev_addr &&
              int'(cls_data) == prev_data, "R9", "held verdict", int'(cls_kind), prev_kind);
      if (hs) begin
        if (q_kind.size() == 0) begin
          check(0, "R9", "unexpected verdict", int'(cls_kind), 0);
        end else begin
          check(int'(cls_kind) == q_kind[0], q_tag[0], "verdict kind", int'(cls_kind), q_kind[0]);
          check(int'(cls_addr) == q_addr[0] && int'(cls_data) == q_data[0], "R9",
                "forwarded address", int'(cls_addr), q_addr[0]);
          void'(q_kind.pop_front()); void'(q_addr.pop_front());
          void'(q_data.pop_front()); void'(q_tag.pop_front());
        end
      end
      prev_stall = cls_valid && !cls_ready;
      prev_kind = int'(cls_kind); prev_addr = int'(cls_addr); prev_data = int'(cls_data);

      gap_hit = (m_idle >= GAP_LIMIT) && (m_step != 0);
      st   = (m_idle >= GAP_LIMIT) ? 0 : m_step;
      arm  = m_arm; pr = m_prot; pend = m_pend;
      if (period_end) begin
        if (pend == 1) pr = 1;
        else if (pend == 2) pr = 0;
        pend = 0; arm = 0; st = 0; gap_hit = 0;
      end
      if (acc) begin
        a = int'(wr_addr[14:0]);
        d = int'(wr_data);
        if (arm) begin
          nk = 2; tag = "R5";
        end else if (key_ok(st, a, d)) begin
          nk = 1;
          tag = (st >= 3 || (st == 2 && d == 'h80)) ? "R3" : "R2";
          if (st == 2 && d == 'hA0) begin arm = 1; pend = 1; st = 0; end
          else if (st == 5) begin pend = 2; st = 0; end
          else st = st + 1;
        end else if (key_ok(0, a, d)) begin
          nk = 1; tag = gap_hit ? "R6" : "R7"; st = 1;
        end else begin
          nk = pr ? 3 : 2; tag = gap_hit ? "R6" : "R4"; st = 0;
        end
        if (period_end) tag = "R10";
        q_kind.push_back(nk); q_addr.push_back(int'(wr_addr));
        q_data.push_back(int'(wr_data)); q_tag.push_back(tag);
        m_idle = 0;
      end else if (m_idle < GAP_LIMIT) begin
        m_idle = m_idle + 1;
      end
      m_step = st; m_arm = arm; m_prot = pr; m_pend = pend;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 cls_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
  end

  task automatic wr(input int addr, input int data);
    @(posedge clk); #2;
    wr_valid = 1'b1;
    wr_addr  = ADDR_W'(addr);
    wr_data  = DATA_W'(data);
    do @(posedge clk); while (!acc_seen);
    #2 wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic end_period();
    @(posedge clk); #2 period_end = 1'b1;
    @(posedge clk); #2 period_end = 1'b0;
  endtask

  task automatic seq_enable(input int hi);
    wr(hi | 'h5555, 'hAA); wr(hi | 'h2AAA, 'h55); wr(hi | 'h5555, 'hA0);
  endtask

  task automatic seq_disable();
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h80);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h20);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    idle(3);
    @(posedge clk); #2 rst_n = 1'b1; nv_rst_n = 1'b1;
    @(negedge clk);
    check(!cls_valid && wr_ready, "R1", "idle after reset", int'(cls_valid), 0);
    check(!protect_o, "R1", "protect after reset", int'(protect_o), 0);

    wr('h00123, 'h11); wr('h00200, 'h22);              // R4 unprotected data
    seq_enable(0); wr('h10, 'h33); wr('h11, 'h44);      // R2 with data, R5
    idle(2); @(negedge clk);
    check(!protect_o, "R2", "protect before period end", int'(protect_o), 0);
    end_period(); @(negedge clk);
    check(protect_o, "R2", "protect after period end", int'(protect_o), 1);

    wr('h40, 'h55); end_period();                        // R4 blocked
    seq_enable(0); end_period(); @(negedge clk);         // R2 no data bytes
    check(protect_o, "R2", "still protected", int'(protect_o), 1);
    seq_enable('h10000); wr('h10080, 'h66); end_period(); // R2 high bit ignored

    wr('h5555, 'hAA); wr('h5555, 'hAA); wr('h2AAA, 'h55); // R7 recheck
    wr('h5555, 'hA0); wr('h90, 'h77); end_period();
    wr('h5555, 'hAA); wr('h2AAA, 'h54); end_period();     // R7 mismatch

    wr('h5555, 'hAA); idle(GAP_LIMIT - 1); wr('h2AAA, 'h55); // R6 abort
    wr('h5555, 'hA0); end_period();
    wr('h5555, 'hAA); idle(GAP_LIMIT - 2); wr('h2AAA, 'h55); // R6 survives
    wr('h5555, 'hA0); wr('h91, 'h78); end_period();

    @(posedge clk); #2 rst_n = 1'b0;                      // R8 normal reset
    idle(2); @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    check(protect_o, "R8", "protect across rst_n", int'(protect_o), 1);

    stall_mode = 1;
    seq_disable(); wr('h300, 'h99); end_period();          // R3 under stalls
    idle(4); @(negedge clk);
    check(!protect_o, "R3", "protect after disable", int'(protect_o), 0);
    wr('h301, 'h9A); wr('h302, 'h9B);
    idle(6); stall_mode = 0; idle(3);

    seq_enable(0); idle(2);                                 // R10 coincidence
    @(posedge clk); #2 period_end = 1'b1; wr_valid = 1'b1;
    wr_addr = ADDR_W'('h500); wr_data = DATA_W'('h5A);
    @(posedge clk); #2 period_end = 1'b0; wr_valid = 1'b0;
    idle(3); @(negedge clk);
    check(protect_o, "R10", "protect set at coincident end", int'(protect_o), 1);

    @(posedge clk); #2 nv_rst_n = 1'b0;                    // R1 persistent reset
    @(posedge clk); #2 nv_rst_n = 1'b1;
    @(negedge clk);
    check(!protect_o, "R1", "protect after nv reset", int'(protect_o), 0);
    wr('h600, 'h01);
    idle(5); @(negedge clk);
    check(q_kind.size() == 0, "R9", "all verdicts delivered", q_kind.size(), 0);
    summary();
  end
endmodule